// File: doc/BRIEF.md
# Dual-Load Banked Data Memory

This block is a tile-local data memory that serves two 512-bit load ports and one 512-bit store port from eight physical banks. Each physical bank is 256 bits wide and 8 KiB deep, and it accepts only one access per clock. The banks are paired and interleaved into four 512-bit virtual banks of 16 KiB each. The lower half of a 512-bit row sits in the even bank of the pair and the upper half in the odd bank, both at the same row index.

When the two load ports issue in the same cycle to different virtual banks, both loads are served at once. When they hit the same virtual bank, port 0 goes first. Port 1 is captured in a hold register and served in the following cycle, and the stall output is high for that one cycle so that a processor pipeline can freeze. A store uses whatever bank bandwidth the loads leave free. Loads always win, and a store that is refused sees its ready signal low and must be held by the requester.

Top module: `bdm_mem`

## Requirements
- R1: The byte address is decoded as follows: bits [15:14] choose the virtual bank, bits [13:6] choose the 512-bit row, and bits [5:0] are ignored. Data stored at an address is read back unchanged through either load port.
- R2: Two loads issued in one cycle to different virtual banks both return `rvalid` with correct data in the next cycle, and `stall` stays low.
- R3: Two loads issued in one cycle to the same virtual bank return port 0 in the next cycle. In that same next cycle `stall` is high and port 1 has no response. Port 1 data returns two cycles after issue.
- R4: `stall` is high for exactly one cycle per conflict. Load requests presented while `stall` is high are ignored and produce no response.
- R5: A load response (`rvalid` with data) appears exactly one cycle after the load is accepted. `rvalid` is low in every cycle that follows a cycle with no accepted load on that port.
- R6: `st_ready` is high only when `st_valid` is high and no load in that cycle uses the store's virtual bank. A store accepted this way is visible to a load issued in the next cycle.
- R7: A store is refused (`st_ready` low) when an accepted load or a held port-1 load uses its virtual bank. A refused store leaves the memory unchanged.
- R8: A load to the same address as a store in the same cycle returns the contents from before the store.
- R9: After reset, `stall`, `ld0_rvalid`, `ld1_rvalid` and `st_ready` (with no store request) are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld0_valid | input | 1 | Load port 0 request |
| ld0_addr | input | 16 | Load port 0 byte address |
| ld0_rvalid | output | 1 | Load port 0 response valid |
| ld0_rdata | output | 512 | Load port 0 read data |
| ld1_valid | input | 1 | Load port 1 request |
| ld1_addr | input | 16 | Load port 1 byte address |
| ld1_rvalid | output | 1 | Load port 1 response valid |
| ld1_rdata | output | 512 | Load port 1 read data |
| st_valid | input | 1 | Store request |
| st_addr | input | 16 | Store byte address |
| st_wdata | input | 512 | Store data |
| st_ready | output | 1 | Store accepted this cycle |
| stall | output | 1 | One-cycle stall while a held port-1 load is served |

## Verification
The checker watches the control timing on every cycle:
- a same-bank pair raises `stall` for one cycle only;
- a held port-1 load is answered right after the stall;
- requests during a stall get no response;
- port 0 has one-cycle latency;
- a store that shares a bank with a port-0 load is refused.

Only the bench scenarios can show that data lands in the right row and halves. They also show that a refused store really leaves memory untouched, and that a colliding load and store return the old contents before the new ones.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int DEF_VB_BITS  = 2;
    localparam int DEF_ROW_BITS = 8;
    localparam int DEF_HALF_W   = 256;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bank_op_e;
endpackage

// File: rtl/bdm_bank.sv
module bdm_bank #(
    parameter int W        = 256,
    parameter int ROW_BITS = 8
) (
    input  logic                clk,
    input  logic                en,
    input  logic                we,
    input  logic [ROW_BITS-1:0] row,
    input  logic [W-1:0]        wdata,
    output logic [W-1:0]        rdata
);
    localparam int ROWS = 1 << ROW_BITS;

    logic [W-1:0] mem_q [ROWS];

    // single access per cycle: either a read or a write
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem_q[row] <= wdata;
            else    rdata      <= mem_q[row];
        end
    end
endmodule

// File: rtl/bdm_arb.sv
module bdm_arb
    import bdm_pkg::*;
#(
    parameter int VB_BITS  = 2,
    parameter int ROW_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld0_valid,
    input  logic [VB_BITS-1:0]  ld0_vb,
    input  logic [ROW_BITS-1:0] ld0_row,
    input  logic                ld1_valid,
    input  logic [VB_BITS-1:0]  ld1_vb,
    input  logic [ROW_BITS-1:0] ld1_row,
    input  logic                st_valid,
    input  logic [VB_BITS-1:0]  st_vb,
    input  logic [ROW_BITS-1:0] st_row,
    output logic                bank_en  [1 << VB_BITS],
    output logic                bank_we  [1 << VB_BITS],
    output logic [ROW_BITS-1:0] bank_row [1 << VB_BITS],
    output logic                st_ready,
    output logic                stall,
    output logic                r0_valid,
    output logic [VB_BITS-1:0]  r0_vb,
    output logic                r1_valid,
    output logic [VB_BITS-1:0]  r1_vb
);
    localparam int NUM_VB = 1 << VB_BITS;

    typedef struct packed {
        logic                pend;
        logic [VB_BITS-1:0]  p_vb;
        logic [ROW_BITS-1:0] p_row;
        logic                r0v;
        logic [VB_BITS-1:0]  r0vb;
        logic                r1v;
        logic [VB_BITS-1:0]  r1vb;
    } arb_state_t;

    arb_state_t s_d, s_q;
    bank_op_e   op [NUM_VB];

    logic                g0, g1, conflict, st_ok;
    logic [VB_BITS-1:0]  a1_vb;
    logic [ROW_BITS-1:0] a1_row;

    always_comb begin
        s_d      = s_q;
        // while a held load drains, new load requests are ignored
        g0       = !s_q.pend && ld0_valid;
        conflict = !s_q.pend && ld0_valid && ld1_valid && (ld0_vb == ld1_vb);
        g1       = s_q.pend || (ld1_valid && !conflict);
        a1_vb    = s_q.pend ? s_q.p_vb  : ld1_vb;
        a1_row   = s_q.pend ? s_q.p_row : ld1_row;
        st_ok    = st_valid && !(g0 && (ld0_vb == st_vb)) && !(g1 && (a1_vb == st_vb));

        for (int k = 0; k < NUM_VB; k++) begin
            op[k]       = OP_IDLE;
            bank_row[k] = '0;
            if (g0 && (ld0_vb == VB_BITS'(k))) begin
                op[k]       = OP_READ;
                bank_row[k] = ld0_row;
            end else if (g1 && (a1_vb == VB_BITS'(k))) begin
                op[k]       = OP_READ;
                bank_row[k] = a1_row;
            end else if (st_ok && (st_vb == VB_BITS'(k))) begin
                op[k]       = OP_WRITE;
                bank_row[k] = st_row;
            end
            bank_en[k] = (op[k] != OP_IDLE);
            bank_we[k] = (op[k] == OP_WRITE);
        end

        s_d.pend  = conflict;
        s_d.p_vb  = ld1_vb;
        s_d.p_row = ld1_row;
        s_d.r0v   = g0;
        s_d.r0vb  = ld0_vb;
        s_d.r1v   = g1;
        s_d.r1vb  = a1_vb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_ready = st_ok;
    assign stall    = s_q.pend;
    assign r0_valid = s_q.r0v;
    assign r0_vb    = s_q.r0vb;
    assign r1_valid = s_q.r1v;
    assign r1_vb    = s_q.r1vb;
endmodule

// File: rtl/bdm_mem.sv
module bdm_mem
    import bdm_pkg::*;
#(
    parameter int VB_BITS  = DEF_VB_BITS,
    parameter int ROW_BITS = DEF_ROW_BITS,
    parameter int HALF_W   = DEF_HALF_W,
    localparam int DATA_W   = 2 * HALF_W,
    localparam int OFF_BITS = $clog2(DATA_W / 8),
    localparam int ADDR_W   = VB_BITS + ROW_BITS + OFF_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld0_valid,
    input  logic [ADDR_W-1:0] ld0_addr,
    output logic              ld0_rvalid,
    output logic [DATA_W-1:0] ld0_rdata,
    input  logic              ld1_valid,
    input  logic [ADDR_W-1:0] ld1_addr,
    output logic              ld1_rvalid,
    output logic [DATA_W-1:0] ld1_rdata,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_wdata,
    output logic              st_ready,
    output logic              stall
);
    localparam int NUM_VB = 1 << VB_BITS;

    logic                bank_en  [NUM_VB];
    logic                bank_we  [NUM_VB];
    logic [ROW_BITS-1:0] bank_row [NUM_VB];
    logic [DATA_W-1:0]   vb_data  [NUM_VB];
    logic [VB_BITS-1:0]  r0_vb, r1_vb;
    logic                unused_offset;

    assign unused_offset = ^{ld0_addr[OFF_BITS-1:0], ld1_addr[OFF_BITS-1:0],
                             st_addr[OFF_BITS-1:0]};

    bdm_arb #(.VB_BITS(VB_BITS), .ROW_BITS(ROW_BITS)) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld0_valid(ld0_valid),
        .ld0_vb   (ld0_addr[ADDR_W-1 -: VB_BITS]),
        .ld0_row  (ld0_addr[OFF_BITS +: ROW_BITS]),
        .ld1_valid(ld1_valid),
        .ld1_vb   (ld1_addr[ADDR_W-1 -: VB_BITS]),
        .ld1_row  (ld1_addr[OFF_BITS +: ROW_BITS]),
        .st_valid (st_valid),
        .st_vb    (st_addr[ADDR_W-1 -: VB_BITS]),
        .st_row   (st_addr[OFF_BITS +: ROW_BITS]),
        .bank_en  (bank_en),
        .bank_we  (bank_we),
        .bank_row (bank_row),
        .st_ready (st_ready),
        .stall    (stall),
        .r0_valid (ld0_rvalid),
        .r0_vb    (r0_vb),
        .r1_valid (ld1_rvalid),
        .r1_vb    (r1_vb)
    );

    // each virtual bank = even bank (low half) + odd bank (high half)
    for (genvar k = 0; k < NUM_VB; k++) begin : g_vbank
        for (genvar h = 0; h < 2; h++) begin : g_half
            bdm_bank #(.W(HALF_W), .ROW_BITS(ROW_BITS)) i_bank (
                .clk  (clk),
                .en   (bank_en[k]),
                .we   (bank_we[k]),
                .row  (bank_row[k]),
                .wdata(st_wdata[h*HALF_W +: HALF_W]),
                .rdata(vb_data[k][h*HALF_W +: HALF_W])
            );
        end
    end

    assign ld0_rdata = vb_data[r0_vb];
    assign ld1_rdata = vb_data[r1_vb];
endmodule

// File: rtl/bdm_mem_chk.sv
module bdm_mem_chk #(
    parameter int ADDR_W  = 16,
    parameter int VB_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld0_valid,
    input logic [ADDR_W-1:0] ld0_addr,
    input logic              ld1_valid,
    input logic [ADDR_W-1:0] ld1_addr,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic              st_ready,
    input logic              stall,
    input logic              ld0_rvalid,
    input logic              ld1_rvalid
);
    logic [VB_BITS-1:0] vb0, vb1, vbs;
    logic               same_vb;

    assign vb0     = ld0_addr[ADDR_W-1 -: VB_BITS];
    assign vb1     = ld1_addr[ADDR_W-1 -: VB_BITS];
    assign vbs     = st_addr[ADDR_W-1 -: VB_BITS];
    assign same_vb = ld0_valid && ld1_valid && (vb0 == vb1);

    // R3
    conflict_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && same_vb) |=> (stall && ld0_rvalid && !ld1_rvalid));
    // R3
    held_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ld1_rvalid);
    // R4
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R4
    stall_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !ld0_rvalid);
    // R2
    no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !same_vb) |=> !stall);
    // R5
    ld0_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ld0_valid) |=> ld0_rvalid);
    // R5
    ld0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld0_valid |=> !ld0_rvalid);
    // R6
    st_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> !st_ready);
    // R6
    st_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !stall && !ld0_valid && !ld1_valid) |-> st_ready);
    // R7
    st_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !stall && ld0_valid && (vbs == vb0)) |-> !st_ready);
endmodule

bind bdm_mem bdm_mem_chk #(.ADDR_W(ADDR_W), .VB_BITS(VB_BITS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld0_valid (ld0_valid),
    .ld0_addr  (ld0_addr),
    .ld1_valid (ld1_valid),
    .ld1_addr  (ld1_addr),
    .st_valid  (st_valid),
    .st_addr   (st_addr),
    .st_ready  (st_ready),
    .stall     (stall),
    .ld0_rvalid(ld0_rvalid),
    .ld1_rvalid(ld1_rvalid)
);

// File: tb/test_bdm_mem.sv
`timescale 1ns/1ps
module test_bdm_mem;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld0_valid = 1'b0, ld1_valid = 1'b0, st_valid = 1'b0;
    logic [15:0]  ld0_addr = '0, ld1_addr = '0, st_addr = '0;
    logic [511:0] st_wdata = '0;
    logic         ld0_rvalid, ld1_rvalid, st_ready, stall;
    logic [511:0] ld0_rdata, ld1_rdata;

    int checks = 0;
    int errors = 0;
    logic [511:0] ref_mem [int];

    always #4 clk = ~clk;

    bdm_mem i_bdm_mem (
        .clk(clk), .rst_n(rst_n),
        .ld0_valid(ld0_valid), .ld0_addr(ld0_addr), .ld0_rvalid(ld0_rvalid), .ld0_rdata(ld0_rdata),
        .ld1_valid(ld1_valid), .ld1_addr(ld1_addr), .ld1_rvalid(ld1_rvalid), .ld1_rdata(ld1_rdata),
        .st_valid(st_valid), .st_addr(st_addr), .st_wdata(st_wdata), .st_ready(st_ready),
        .stall(stall)
    );

    // stimulus table: {ld0_valid, ld0_addr, ld1_valid, ld1_addr}
    localparam logic [33:0] VEC [8] = '{
        {1'b1, 16'h0000, 1'b1, 16'h40C0},
        {1'b1, 16'h81C0, 1'b1, 16'hF200},
        {1'b1, 16'h0000, 1'b1, 16'h0040},
        {1'b1, 16'h3FC0, 1'b1, 16'h3FC0},
        {1'b1, 16'hF200, 1'b0, 16'h0000},
        {1'b0, 16'h0000, 1'b1, 16'h40C0},
        {1'b1, 16'h40C0, 1'b1, 16'h0000},
        {1'b1, 16'h81C0, 1'b1, 16'h81C0}
    };
    localparam logic [15:0] PRELOAD [7] = '{16'h0000, 16'h0040, 16'h3FC0, 16'h40C0,
                                            16'h81C0, 16'hF200, 16'h4000};

    function automatic int key_of(logic [15:0] a);
        return int'(a[15:6]);
    endfunction

    function automatic logic [511:0] pat(logic [15:0] a, logic [7:0] gen);
        logic [511:0] v;
        for (int i = 0; i < 16; i++)
            v[i*32 +: 32] = {gen, 4'(i), 10'(a[15:6]), 10'h2A5};
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [15:0] a, input logic [511:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_wdata = d;
        #1;
        chk(st_ready === 1'b1, "R6 store accepted on idle bank", 512'(st_ready), 512'd1);
        @(negedge clk);
        st_valid = 1'b0;
        ref_mem[key_of(a)] = d;
    endtask

    task automatic do_pair(input logic v0, input logic [15:0] a0,
                           input logic v1, input logic [15:0] a1);
        bit conf;
        conf = v0 && v1 && (a0[15:14] == a1[15:14]);
        @(negedge clk);
        ld0_valid = v0; ld0_addr = a0; ld1_valid = v1; ld1_addr = a1;
        @(negedge clk);
        ld0_valid = 1'b0; ld1_valid = 1'b0;
        chk(ld0_rvalid === v0, "R5 port0 rvalid latency", 512'(ld0_rvalid), 512'(v0));
        if (v0)
            chk(ld0_rdata === ref_mem[key_of(a0)], "R1 port0 data",
                ld0_rdata, ref_mem[key_of(a0)]);
        chk(stall === conf, conf ? "R3 stall on same bank" : "R2 no stall on distinct banks",
            512'(stall), 512'(conf));
        if (!conf) begin
            chk(ld1_rvalid === v1, "R2 port1 rvalid same cycle", 512'(ld1_rvalid), 512'(v1));
            if (v1)
                chk(ld1_rdata === ref_mem[key_of(a1)], "R2 port1 data",
                    ld1_rdata, ref_mem[key_of(a1)]);
        end else begin
            chk(ld1_rvalid === 1'b0, "R3 port1 held", 512'(ld1_rvalid), 512'd0);
            @(negedge clk);
            chk(stall === 1'b0, "R4 stall one cycle", 512'(stall), 512'd0);
            chk(ld1_rvalid === 1'b1, "R3 port1 served after stall", 512'(ld1_rvalid), 512'd1);
            chk(ld1_rdata === ref_mem[key_of(a1)], "R3 port1 data",
                ld1_rdata, ref_mem[key_of(a1)]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [511:0] old_d;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(stall === 1'b0, "R9 stall after reset", 512'(stall), 512'd0);
        chk(ld0_rvalid === 1'b0 && ld1_rvalid === 1'b0, "R9 rvalid after reset",
            512'({ld0_rvalid, ld1_rvalid}), 512'd0);
        chk(st_ready === 1'b0, "R9 st_ready after reset", 512'(st_ready), 512'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 7; i++) do_store(PRELOAD[i], pat(PRELOAD[i], 8'h11));

        for (int i = 0; i < 8; i++)
            do_pair(VEC[i][33], VEC[i][32:17], VEC[i][16], VEC[i][15:0]);

        // R1 offset bits ignored
        do_pair(1'b1, 16'h81D5, 1'b1, 16'h003F);

        // R7 store refused by port0 load in same bank, then accepted
        @(negedge clk);
        ld0_valid = 1'b1; ld0_addr = 16'h40C0;
        st_valid = 1'b1; st_addr = 16'h4000; st_wdata = pat(16'h4000, 8'h22);
        #1;
        chk(st_ready === 1'b0, "R7 store blocked by port0", 512'(st_ready), 512'd0);
        @(negedge clk);
        ld0_valid = 1'b0;
        chk(ld0_rdata === ref_mem[key_of(16'h40C0)], "R7 load wins data",
            ld0_rdata, ref_mem[key_of(16'h40C0)]);
        #1;
        chk(st_ready === 1'b1, "R6 retried store accepted", 512'(st_ready), 512'd1);
        @(negedge clk);
        st_valid = 1'b0;
        ref_mem[key_of(16'h4000)] = pat(16'h4000, 8'h22);
        do_pair(1'b1, 16'h4000, 1'b0, 16'h0000);

        // R8 load and store to same address: old contents first
        old_d = ref_mem[key_of(16'h0000)];
        @(negedge clk);
        ld0_valid = 1'b1; ld0_addr = 16'h0000;
        st_valid = 1'b1; st_addr = 16'h0000; st_wdata = pat(16'h0000, 8'h33);
        #1;
        chk(st_ready === 1'b0, "R8 colliding store deferred", 512'(st_ready), 512'd0);
        @(negedge clk);
        ld0_valid = 1'b0;
        chk(ld0_rdata === old_d, "R8 old contents returned", ld0_rdata, old_d);
        @(negedge clk);
        st_valid = 1'b0;
        ref_mem[key_of(16'h0000)] = pat(16'h0000, 8'h33);
        do_pair(1'b0, 16'h0000, 1'b1, 16'h0000);

        // R4 / R7 requests during stall: loads ignored, store to held bank refused
        @(negedge clk);
        ld0_valid = 1'b1; ld0_addr = 16'h0000; ld1_valid = 1'b1; ld1_addr = 16'h0040;
        @(negedge clk);
        ld0_addr = 16'h81C0; ld1_addr = 16'hF200;
        st_valid = 1'b1; st_addr = 16'h0040; st_wdata = pat(16'h0040, 8'h44);
        chk(stall === 1'b1, "R3 stall raised", 512'(stall), 512'd1);
        #1;
        chk(st_ready === 1'b0, "R7 store blocked by held load", 512'(st_ready), 512'd0);
        @(negedge clk);
        ld0_valid = 1'b0; ld1_valid = 1'b0; st_valid = 1'b0;
        chk(ld0_rvalid === 1'b0, "R4 port0 request during stall ignored",
            512'(ld0_rvalid), 512'd0);
        chk(ld1_rvalid === 1'b1 && ld1_rdata === ref_mem[key_of(16'h0040)],
            "R4 held load returned", ld1_rdata, ref_mem[key_of(16'h0040)]);
        @(negedge clk);
        chk(ld1_rvalid === 1'b0, "R4 port1 request during stall ignored",
            512'(ld1_rvalid), 512'd0);
        do_pair(1'b1, 16'h0040, 1'b0, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule